// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block is a small register file with a data port. Through it a host moves bytes into and out of a network controller's packet buffer. The buffer is an internal two-bank SRAM. The host programs a start address and a remaining byte count, each as two byte registers. It then writes a command byte that selects a remote read or a remote write and sets the start bit. From then on every data port strobe moves one byte, or one 16-bit little-endian word, and advances the address and the count. Nothing else moves data.

When the count runs out, or the host aborts the transfer, a completion flag is raised in a write-one-to-clear status register. That register also holds a reset flag that is set when the block leaves reset. The command, status and configuration registers come out of reset in fixed non-zero states.

The configuration register has a width bit that selects byte or word data port accesses. The width also selects where the buffer appears in the 16-bit remote address space. In word mode the window starts at `WORD_BASE` and is `RAM_BYTES` long. In byte mode the window starts at `BYTE_BASE` and is `RAM_BYTES/2` long, and it maps onto the low half of the same storage. A full-size instance uses `RAM_BYTES` = 16384. The register bus uses plain byte read and write strobes with a combinational read path. Media access, packet reception and packet transmission belong to other blocks.

Top module: `nic_rdma_port`

## Requirements
- R1: After reset the registers read as follows: command (offset 0) 0x21, status (offset 5) 0x80, interrupt mask (offset 6) 0x00, data configuration (offset 7) 0x08, transmit configuration (offset 8) 0x06, and the address and count registers (offsets 1 to 4) read 0x00.
- R2: A write to offset 1 or 2 loads the low or high byte of the current remote address, and a write to offset 3 or 4 loads the low or high byte of the remaining count. Reads of these four offsets return the live address and count at every moment, including during a transfer.
- R3: A command write starts a transfer only when it has the start bit (bit 1) set, the abort bit (bit 5) clear, and exactly one of the read bit (bit 3) and the write bit (bit 4) set. A command write with both direction bits set, or with the start bit clear, starts nothing.
- R4: When the width bit (bit 0 of offset 7) is clear, each accepted data port access moves one byte on data bits 7:0. The address then rises by 1 and the count falls by 1. Bits 15:8 of the read data are 0 in this mode.
- R5: When the width bit is set, each accepted access moves two bytes. The byte at the current address is on bits 7:0 and the byte at the next address is on bits 15:8. The address then rises by 2, and the count falls by 2 or to 0, whichever is the smaller drop.
- R6: The completion flag (status bit 6) is set on the same clock edge on which the count reaches 0, and the transfer ends there. A transfer started with a count of 0 ends at once and sets the flag.
- R7: Writing to the status register clears every bit written as 1 and leaves every bit written as 0 unchanged. Writing 0xFF clears both the completion flag and the reset flag (bit 7).
- R8: A command write with the abort bit set during a transfer ends the transfer at once and sets the completion flag. The address and count keep the values they had at that moment.
- R9: Data port accesses while no transfer runs, and accesses in the direction opposite to the running transfer, do not change the address, the count or the buffer. Reads made this way return 0.
- R10: A buffer byte outside the window of the current width is never written, and it reads as 0xFF. A byte-mode address `BYTE_BASE+k` and a word-mode address `WORD_BASE+k` name the same stored byte.
- R11: The interrupt mask and both configuration registers store the full byte written and read it back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; gates reg_rdata |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid while reg_rd is high |
| port_rd | input | 1 | Data port read strobe |
| port_wr | input | 1 | Data port write strobe |
| port_wdata | input | 16 | Data port write data |
| port_rdata | output | 16 | Data port read data, valid while port_rd is high |

## Verification
The bench targets the final access of a word-mode transfer with an odd count. A design that subtracted 2 blindly would wrap the count to 0xFFFF and never raise the completion flag. It aborts a write partway through and then strobes the port again. A design that kept the engine armed would go on decrementing the count. It sends command bytes with both direction bits set, or with the start bit clear. A loose decoder would start a transfer there, and the following data port read would return buffer data instead of 0. It reads across the edge of the buffer window and reads one stored byte through both window aliases. A wrong base, limit or lane order shows up there as wrong data or as 0xFF where data is expected.

// File: rtl/nic_rdma_pkg.sv
package nic_rdma_pkg;
  // remote address / count width: two byte registers each
  localparam int RA_W = 16;

  // register offsets
  localparam logic [3:0] OFS_CMD     = 4'd0;
  localparam logic [3:0] OFS_ADDR_LO = 4'd1;
  localparam logic [3:0] OFS_ADDR_HI = 4'd2;
  localparam logic [3:0] OFS_CNT_LO  = 4'd3;
  localparam logic [3:0] OFS_CNT_HI  = 4'd4;
  localparam logic [3:0] OFS_STAT    = 4'd5;
  localparam logic [3:0] OFS_MASK    = 4'd6;
  localparam logic [3:0] OFS_DCFG    = 4'd7;
  localparam logic [3:0] OFS_TCFG    = 4'd8;

  // command bits
  localparam int CMD_STA     = 1;
  localparam int CMD_DIR_RD  = 3;
  localparam int CMD_DIR_WR  = 4;
  localparam int CMD_ABORT   = 5;

  // status bits
  localparam int STAT_DONE   = 6;
  localparam int STAT_RSTF   = 7;

  // data configuration bits
  localparam int DCFG_WIDE   = 0;

  // reset values
  localparam logic [7:0] CMD_RST  = 8'h21;
  localparam logic [7:0] STAT_RST = 8'h80;
  localparam logic [7:0] MASK_RST = 8'h00;
  localparam logic [7:0] DCFG_RST = 8'h08;
  localparam logic [7:0] TCFG_RST = 8'h06;

  // byte loads into the address/count engine
  typedef struct packed {
    logic       addr_lo;
    logic       addr_hi;
    logic       cnt_lo;
    logic       cnt_hi;
    logic [7:0] data;
  } eng_load_t;
endpackage

// File: rtl/nic_rdma_regs.sv
module nic_rdma_regs
  import nic_rdma_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [3:0]      reg_addr,
  input  logic [7:0]      reg_wdata,
  input  logic            xfer_done,
  input  logic [RA_W-1:0] cur_addr,
  input  logic [RA_W-1:0] cur_cnt,
  output logic [7:0]      rb_data,
  output logic            wide,
  output logic            done_flag,
  output logic            start_rd,
  output logic            start_wr,
  output logic            abort,
  output eng_load_t       eng_ld
);
  logic [7:0] cmd_q, cmd_d, stat_q, stat_d, mask_q, mask_d;
  logic [7:0] dcfg_q, dcfg_d, tcfg_q, tcfg_d;
  logic       reg_en, cmd_wr, dir_one;

  assign cmd_wr  = reg_wr && (reg_addr == OFS_CMD);
  assign dir_one = reg_wdata[CMD_DIR_RD] ^ reg_wdata[CMD_DIR_WR];

  assign abort    = cmd_wr && reg_wdata[CMD_ABORT];
  assign start_rd = cmd_wr && !reg_wdata[CMD_ABORT] && reg_wdata[CMD_STA] &&
                    dir_one && reg_wdata[CMD_DIR_RD];
  assign start_wr = cmd_wr && !reg_wdata[CMD_ABORT] && reg_wdata[CMD_STA] &&
                    dir_one && reg_wdata[CMD_DIR_WR];

  assign eng_ld.addr_lo = reg_wr && (reg_addr == OFS_ADDR_LO);
  assign eng_ld.addr_hi = reg_wr && (reg_addr == OFS_ADDR_HI);
  assign eng_ld.cnt_lo  = reg_wr && (reg_addr == OFS_CNT_LO);
  assign eng_ld.cnt_hi  = reg_wr && (reg_addr == OFS_CNT_HI);
  assign eng_ld.data    = reg_wdata;

  assign wide      = dcfg_q[DCFG_WIDE];
  assign done_flag = stat_q[STAT_DONE];
  assign reg_en    = reg_wr || xfer_done;

  // next state
  always_comb begin
    cmd_d  = cmd_q;
    stat_d = stat_q;
    mask_d = mask_q;
    dcfg_d = dcfg_q;
    tcfg_d = tcfg_q;
    if (reg_wr) begin
      case (reg_addr)
        OFS_CMD:  cmd_d  = reg_wdata;
        OFS_STAT: stat_d = stat_q & ~reg_wdata;
        OFS_MASK: mask_d = reg_wdata;
        OFS_DCFG: dcfg_d = reg_wdata;
        OFS_TCFG: tcfg_d = reg_wdata;
        default:  ;
      endcase
    end
    if (xfer_done) stat_d[STAT_DONE] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_RST;
      stat_q <= STAT_RST;
      mask_q <= MASK_RST;
      dcfg_q <= DCFG_RST;
      tcfg_q <= TCFG_RST;
    end else if (reg_en) begin
      cmd_q  <= cmd_d;
      stat_q <= stat_d;
      mask_q <= mask_d;
      dcfg_q <= dcfg_d;
      tcfg_q <= tcfg_d;
    end
  end

  // readback
  always_comb begin
    case (reg_addr)
      OFS_CMD:     rb_data = cmd_q;
      OFS_ADDR_LO: rb_data = cur_addr[7:0];
      OFS_ADDR_HI: rb_data = cur_addr[15:8];
      OFS_CNT_LO:  rb_data = cur_cnt[7:0];
      OFS_CNT_HI:  rb_data = cur_cnt[15:8];
      OFS_STAT:    rb_data = stat_q;
      OFS_MASK:    rb_data = mask_q;
      OFS_DCFG:    rb_data = dcfg_q;
      OFS_TCFG:    rb_data = tcfg_q;
      default:     rb_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/nic_rdma_xfer.sv
module nic_rdma_xfer
  import nic_rdma_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wide,
  input  logic            start_rd,
  input  logic            start_wr,
  input  logic            abort,
  input  eng_load_t       eng_ld,
  input  logic            port_rd,
  input  logic            port_wr,
  output logic            active,
  output logic            acc_rd,
  output logic            acc_wr,
  output logic            done,
  output logic [RA_W-1:0] cur_addr,
  output logic [RA_W-1:0] cur_cnt
);
  logic            act_q, act_d, dir_q, dir_d;
  logic [RA_W-1:0] addr_q, addr_d, cnt_q, cnt_d, step;
  logic            eng_en;

  assign step   = wide ? RA_W'(2) : RA_W'(1);
  assign acc_rd = act_q && !dir_q && port_rd && !abort;
  assign acc_wr = act_q &&  dir_q && port_wr && !abort;
  assign eng_en = abort || start_rd || start_wr || acc_rd || acc_wr ||
                  eng_ld.addr_lo || eng_ld.addr_hi || eng_ld.cnt_lo || eng_ld.cnt_hi;

  always_comb begin
    act_d  = act_q;
    dir_d  = dir_q;
    addr_d = addr_q;
    cnt_d  = cnt_q;
    done   = 1'b0;
    if (abort) begin
      done  = act_q;
      act_d = 1'b0;
    end else if (start_rd || start_wr) begin
      dir_d = start_wr;
      if (cnt_q == '0) done  = 1'b1;
      else             act_d = 1'b1;
    end else if (acc_rd || acc_wr) begin
      addr_d = addr_q + step;
      if (cnt_q <= step) begin
        cnt_d = '0;
        act_d = 1'b0;
        done  = 1'b1;
      end else begin
        cnt_d = cnt_q - step;
      end
    end else begin
      if (eng_ld.addr_lo) addr_d[7:0]  = eng_ld.data;
      if (eng_ld.addr_hi) addr_d[15:8] = eng_ld.data;
      if (eng_ld.cnt_lo)  cnt_d[7:0]   = eng_ld.data;
      if (eng_ld.cnt_hi)  cnt_d[15:8]  = eng_ld.data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      dir_q  <= 1'b0;
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (eng_en) begin
      act_q  <= act_d;
      dir_q  <= dir_d;
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign active   = act_q;
  assign cur_addr = addr_q;
  assign cur_cnt  = cnt_q;
endmodule

// File: rtl/nic_rdma_ram.sv
module nic_rdma_ram
  import nic_rdma_pkg::*;
#(
  parameter int RAM_BYTES = 2048,
  parameter int BYTE_BASE = 8192,
  parameter int WORD_BASE = 16384
) (
  input  logic            clk,
  input  logic            wide,
  input  logic [RA_W-1:0] addr,
  input  logic            we,
  input  logic [15:0]     wdata,
  output logic [15:0]     rdata
);
  localparam int HALF  = RAM_BYTES / 2;
  localparam int OFF_W = $clog2(RAM_BYTES);
  localparam int LANES = 2;
  localparam logic [RA_W:0] WB = (RA_W+1)'(WORD_BASE);
  localparam logic [RA_W:0] BB = (RA_W+1)'(BYTE_BASE);
  localparam logic [RA_W:0] WL = (RA_W+1)'(RAM_BYTES);
  localparam logic [RA_W:0] BL = (RA_W+1)'(HALF);

  logic [7:0]       bank [LANES][HALF];
  logic [RA_W:0]    base, lim;
  logic             ln_en  [LANES];
  logic             ln_hit [LANES];
  logic [OFF_W-1:0] ln_off [LANES];
  logic [7:0]       ln_rd  [LANES];

  assign base = wide ? WB : BB;
  assign lim  = wide ? WL : BL;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [RA_W:0] la, diff;
    assign la        = {1'b0, addr} + (RA_W+1)'(g);
    assign diff      = la - base;
    assign ln_en[g]  = (g == 0) || wide;
    assign ln_hit[g] = (la >= base) && (diff < lim);
    assign ln_off[g] = diff[OFF_W-1:0];
    assign ln_rd[g]  = !ln_en[g]  ? 8'h00 :
                       !ln_hit[g] ? 8'hFF :
                       bank[ln_off[g][0]][ln_off[g][OFF_W-1:1]];
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (we && ln_en[l] && ln_hit[l])
        bank[ln_off[l][0]][ln_off[l][OFF_W-1:1]] <= wdata[8*l +: 8];
    end
  end

  assign rdata = {ln_rd[1], ln_rd[0]};
endmodule

// File: rtl/nic_rdma_port.sv
module nic_rdma_port
  import nic_rdma_pkg::*;
#(
  parameter int RAM_BYTES = 2048,
  parameter int BYTE_BASE = 8192,
  parameter int WORD_BASE = 16384
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [3:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        port_rd,
  input  logic        port_wr,
  input  logic [15:0] port_wdata,
  output logic [15:0] port_rdata
);
  logic [1:0]      rst_sync_q;
  logic            rst_n_int;
  logic [7:0]      rb_data;
  logic            wide, done_flag, start_rd, start_wr, abort;
  logic            active, acc_rd, acc_wr, done;
  logic [RA_W-1:0] cur_addr, cur_cnt;
  logic [15:0]     ram_rdata;
  eng_load_t       eng_ld;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  nic_rdma_regs u_regs (
    .clk(clk), .rst_n(rst_n_int), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .xfer_done(done), .cur_addr(cur_addr),
    .cur_cnt(cur_cnt), .rb_data(rb_data), .wide(wide), .done_flag(done_flag),
    .start_rd(start_rd), .start_wr(start_wr), .abort(abort), .eng_ld(eng_ld)
  );

  nic_rdma_xfer u_xfer (
    .clk(clk), .rst_n(rst_n_int), .wide(wide), .start_rd(start_rd),
    .start_wr(start_wr), .abort(abort), .eng_ld(eng_ld), .port_rd(port_rd),
    .port_wr(port_wr), .active(active), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .done(done), .cur_addr(cur_addr), .cur_cnt(cur_cnt)
  );

  nic_rdma_ram #(
    .RAM_BYTES(RAM_BYTES), .BYTE_BASE(BYTE_BASE), .WORD_BASE(WORD_BASE)
  ) u_ram (
    .clk(clk), .wide(wide), .addr(cur_addr), .we(acc_wr),
    .wdata(port_wdata), .rdata(ram_rdata)
  );

  assign reg_rdata  = reg_rd ? rb_data : 8'h00;
  assign port_rdata = acc_rd ? ram_rdata : 16'h0000;
endmodule

// File: rtl/nic_rdma_chk.sv
module nic_rdma_chk
  import nic_rdma_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            active,
  input logic            acc_rd,
  input logic            acc_wr,
  input logic            wide,
  input logic            done,
  input logic            done_flag,
  input logic            abort,
  input logic            port_rd,
  input logic [15:0]     port_rdata,
  input logic            reg_wr,
  input logic [3:0]      reg_addr,
  input logic [7:0]      reg_wdata,
  input logic [RA_W-1:0] cur_addr,
  input logic [RA_W-1:0] cur_cnt
);
  // R6: a running transfer always has bytes left
  assert_active_cnt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cur_cnt != '0));

  // R4: byte access drops the count by one
  assert_byte_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_rd || acc_wr) && !wide) |=> (cur_cnt == $past(cur_cnt) - RA_W'(1)));

  // R5: word access moves the address by two
  assert_word_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_rd || acc_wr) && wide) |=> (cur_addr == $past(cur_addr) + RA_W'(2)));

  // R9: idle reads return zero
  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (port_rd && !active) |-> (port_rdata == 16'h0000));

  // R6: completion raises the flag
  assert_done_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done_flag);

  // R7: write-one clears the flag
  assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_STAT && reg_wdata[STAT_DONE] && !done) |=> !done_flag);

  // R8: abort stops the engine
  assert_abort_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !active);
endmodule

bind nic_rdma_port nic_rdma_chk u_chk (
  .clk(clk), .rst_n(rst_n_int), .active(active), .acc_rd(acc_rd),
  .acc_wr(acc_wr), .wide(wide), .done(done), .done_flag(done_flag),
  .abort(abort), .port_rd(port_rd), .port_rdata(port_rdata),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .cur_addr(cur_addr), .cur_cnt(cur_cnt)
);

// File: tb/tb_nic_rdma_port.sv
`timescale 1ns/1ps
module tb_nic_rdma_port;
  localparam int RAM_BYTES = 2048;
  localparam int HALF      = RAM_BYTES / 2;
  localparam int BYTE_BASE = 8192;
  localparam int WORD_BASE = 16384;

  logic        clk, rst_n, reg_wr, reg_rd, port_rd, port_wr;
  logic [3:0]  reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic [15:0] port_wdata, port_rdata;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] bmem [RAM_BYTES];
  bit         bval [RAM_BYTES];

  nic_rdma_port #(.RAM_BYTES(RAM_BYTES), .BYTE_BASE(BYTE_BASE), .WORD_BASE(WORD_BASE)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .port_rd(port_rd), .port_wr(port_wr), .port_wdata(port_wdata),
    .port_rdata(port_rdata)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4*150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  // window offset of a byte, -1 when outside
  function automatic int win_off(bit word, int a);
    int base = word ? WORD_BASE : BYTE_BASE;
    int lim  = word ? RAM_BYTES : HALF;
    if (a >= base && a < base + lim) return a - base;
    return -1;
  endfunction

  task automatic wr_reg(logic [3:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_reg(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    reg_rd = 0;
  endtask

  task automatic pwrite(logic [15:0] d);
    @(negedge clk); port_wr = 1; port_wdata = d;
    @(negedge clk); port_wr = 0;
  endtask

  task automatic pread(output logic [15:0] d);
    @(negedge clk); port_rd = 1;
    #1 d = port_rdata;
    @(negedge clk); port_rd = 0;
  endtask

  task automatic setup(bit word, int start, int len, logic [7:0] cmd);
    wr_reg(4'd7, word ? 8'h09 : 8'h08);
    wr_reg(4'd5, 8'h40);
    wr_reg(4'd1, start[7:0]);
    wr_reg(4'd2, start[15:8]);
    wr_reg(4'd3, len[7:0]);
    wr_reg(4'd4, len[15:8]);
    wr_reg(4'd0, cmd);
  endtask

  task automatic read_cnt(output int c);
    logic [7:0] lo, hi;
    rd_reg(4'd3, lo); rd_reg(4'd4, hi);
    c = {hi, lo};
  endtask

  task automatic read_addr(output int a);
    logic [7:0] lo, hi;
    rd_reg(4'd1, lo); rd_reg(4'd2, hi);
    a = {hi, lo};
  endtask

  task automatic do_write(bit word, int start, int len, string req);
    int n = word ? (len + 1) / 2 : len;
    int a = start;
    setup(word, start, len, 8'h12);
    for (int i = 0; i < n; i++) begin
      logic [15:0] d = 16'($urandom);
      if (!word) d[15:8] = 8'h00;
      for (int l = 0; l < (word ? 2 : 1); l++) begin
        int o = win_off(word, a + l);
        if (o >= 0) begin bmem[o] = d[8*l +: 8]; bval[o] = 1; end
      end
      pwrite(d);
      a += word ? 2 : 1;
    end
    begin
      int c, ad; logic [7:0] s;
      read_cnt(c);  chk({req, " count zero after write"}, c, 0);
      read_addr(ad); chk({req, " address after write"}, ad, a & 16'hFFFF);
      rd_reg(4'd5, s); chk({req, " R6 done flag after write"}, s[6], 1);
    end
  endtask

  task automatic do_read(bit word, int start, int len, string req);
    int n = word ? (len + 1) / 2 : len;
    int a = start;
    logic [7:0] s;
    setup(word, start, len, 8'h0A);
    for (int i = 0; i < n; i++) begin
      logic [15:0] d;
      pread(d);
      for (int l = 0; l < 2; l++) begin
        int o = win_off(word, a + l);
        if (l == 1 && !word) chk({req, " R4 upper lane zero"}, d[15:8], 0);
        else if (o < 0) chk({req, " R10 outside window"}, d[8*l +: 8], 8'hFF);
        else if (bval[o]) chk({req, " read data"}, d[8*l +: 8], bmem[o]);
      end
      a += word ? 2 : 1;
    end
    rd_reg(4'd5, s);
    chk({req, " R6 done flag after read"}, s[6], 1);
  endtask

  initial begin
    logic [7:0]  r;
    logic [15:0] d;
    int c, a;
    void'($urandom(32'd20241));
    for (int i = 0; i < RAM_BYTES; i++) bval[i] = 0;
    reg_wr = 0; reg_rd = 0; port_rd = 0; port_wr = 0;
    reg_addr = 0; reg_wdata = 0; port_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: reset values
    rd_reg(4'd0, r); chk("R1 command reset", r, 8'h21);
    rd_reg(4'd5, r); chk("R1 status reset", r, 8'h80);
    rd_reg(4'd6, r); chk("R1 mask reset", r, 8'h00);
    rd_reg(4'd7, r); chk("R1 data config reset", r, 8'h08);
    rd_reg(4'd8, r); chk("R1 transmit config reset", r, 8'h06);
    read_addr(a); chk("R1 address reset", a, 0);
    read_cnt(c);  chk("R1 count reset", c, 0);

    // R7: write-one-to-clear
    wr_reg(4'd5, 8'h00); rd_reg(4'd5, r); chk("R7 zero write keeps bits", r, 8'h80);
    wr_reg(4'd5, 8'h40); rd_reg(4'd5, r); chk("R7 other bit kept", r, 8'h80);
    wr_reg(4'd5, 8'hFF); rd_reg(4'd5, r); chk("R7 0xFF clears all", r, 8'h00);

    // R11: plain storage
    wr_reg(4'd6, 8'h3C); rd_reg(4'd6, r); chk("R11 mask store", r, 8'h3C);
    wr_reg(4'd8, 8'hA5); rd_reg(4'd8, r); chk("R11 transmit config store", r, 8'hA5);

    // R2: load and read back address and count
    wr_reg(4'd1, 8'h12); wr_reg(4'd2, 8'h40);
    wr_reg(4'd3, 8'h34); wr_reg(4'd4, 8'h01);
    read_addr(a); chk("R2 address load", a, 16'h4012);
    read_cnt(c);  chk("R2 count load", c, 16'h0134);

    // R6: start with zero count completes at once
    setup(1'b0, BYTE_BASE, 0, 8'h0A);
    rd_reg(4'd5, r); chk("R6 zero count done", r[6], 1);

    // R9: idle read returns zero, idle write ignored
    pread(d); chk("R9 idle read zero", d, 0);
    pwrite(16'h00EE);
    read_cnt(c); chk("R9 idle write keeps count", c, 0);

    // R4: directed byte transfer and readback
    do_write(1'b0, BYTE_BASE + 40, 6, "R4 byte write");
    do_read(1'b0, BYTE_BASE + 40, 6, "R4 byte read");

    // R5: word transfer with odd count saturates
    do_write(1'b1, WORD_BASE + 100, 4, "R5 word write");
    setup(1'b1, WORD_BASE + 100, 3, 8'h0A);
    pread(d); chk("R5 word lanes first", d, {bmem[101], bmem[100]});
    read_cnt(c); chk("R5 count after first word", c, 1);
    pread(d); chk("R5 word lanes second", d, {bmem[103], bmem[102]});
    read_cnt(c); chk("R5 count saturates to zero", c, 0);
    rd_reg(4'd5, r); chk("R6 done on odd word count", r[6], 1);

    // R3: malformed commands start nothing
    setup(1'b0, BYTE_BASE + 40, 5, 8'h1A);
    pread(d); chk("R3 both directions no start", d, 0);
    read_cnt(c); chk("R3 both directions count kept", c, 5);
    wr_reg(4'd0, 8'h08);
    pread(d); chk("R3 no start bit no start", d, 0);
    read_cnt(c); chk("R3 no start bit count kept", c, 5);

    // R9: wrong direction ignored
    setup(1'b0, BYTE_BASE + 40, 5, 8'h0A);
    pwrite(16'h0077);
    read_cnt(c); chk("R9 wrong direction count kept", c, 5);
    wr_reg(4'd0, 8'h22);
    do_read(1'b0, BYTE_BASE + 40, 6, "R9 buffer untouched");

    // R8: abort mid transfer
    setup(1'b0, BYTE_BASE + 200, 10, 8'h12);
    pwrite(16'h0011); bmem[200] = 8'h11; bval[200] = 1;
    pwrite(16'h0022); bmem[201] = 8'h22; bval[201] = 1;
    wr_reg(4'd0, 8'h22);
    rd_reg(4'd5, r); chk("R8 abort sets done", r[6], 1);
    read_cnt(c); chk("R8 count held at abort", c, 8);
    pwrite(16'h0033);
    read_cnt(c); chk("R8 no access after abort", c, 8);
    read_addr(a); chk("R8 address held after abort", a, BYTE_BASE + 202);

    // R10: aliasing and window edges
    do_write(1'b0, BYTE_BASE + 20, 1, "R10 alias byte write");
    do_read(1'b1, WORD_BASE + 20, 2, "R10 alias word read");
    do_read(1'b0, BYTE_BASE + HALF - 1, 2, "R10 byte window edge");
    do_write(1'b1, WORD_BASE - 2, 2, "R10 below window write");
    do_read(1'b1, WORD_BASE - 2, 2, "R10 below window read");
    do_read(1'b1, WORD_BASE + RAM_BYTES - 2, 4, "R10 word window edge");

    // random transfers, R4 and R5
    for (int it = 0; it < 24; it++) begin
      bit word = 1'($urandom);
      int len  = int'($urandom_range(1, 24));
      int st   = word ? WORD_BASE + 2 * int'($urandom_range(0, (RAM_BYTES - 64) / 2))
                      : BYTE_BASE + int'($urandom_range(0, HALF - 32));
      do_write(word, st, len, word ? "R5 random write" : "R4 random write");
      do_read(word, st, len, word ? "R5 random read" : "R4 random read");
    end

    summary();
  end
endmodule